// File: doc/BRIEF.md
# Two-Stage Overvoltage Protection Element

This block watches a stream of voltage magnitudes, one value per sample-valid strobe, already filtered to the fundamental upstream. It compares each value against two independent thresholds, a lower stage and a higher stage. Each stage latches a pickup flag when the value rises above its threshold. The flag is held, with hysteresis, until the value drops below a drop-off level. That level is the threshold scaled by a settable reset ratio below one. Once a stage has picked up, its own delay timer runs, and the stage raises a trip flag when the delay has elapsed.

An optional restraint holds back pickup until a run of consecutive samples, all above the threshold, has been seen. The run length is a parameter. Four blocking sources clear both stages at once: a user block, a voltage-failure indication, a transformer breaker-trip indication and a single-pole dead-time indication. Settings are unsigned fixed-point register inputs. They are captured while reset is held and on any clock where the load strobe is high.

Top module: `ovp_two_stage`

## Requirements
- R1: In every clock where rst_n is low, pickup and trip flags, timers and restraint counters clear, and the settings inputs are captured. After reset all four flag outputs read 0.
- R2: A stage that is not picked up, with restraint disabled, sets its pickup flag on the clock edge where smp_vld is high and smp_mag is strictly greater than its threshold. A value equal to the threshold does not pick up.
- R3: A picked-up stage stays picked up until a valid sample is strictly below its drop-off level, floor(threshold * ratio / 2^RW), where the ratio is an RW-bit fraction. A sample equal to the drop-off level keeps the pickup.
- R4: With cfg_restraint_en captured as 1, pickup needs RESTRAINT_N consecutive valid samples above the threshold. A valid sample that is not above the threshold restarts the count. Cycles with smp_vld low neither advance nor restart it.
- R5: With a captured delay D, the trip flag rises D+1 clocks after the pickup flag rises. With D = 0 it rises on the clock after pickup. The trip flag then holds while pickup holds.
- R6: On the same clock edge that a stage's pickup clears, its trip flag clears.
- R7: The two stages are independent: each has its own threshold, ratio and delay, and each can be picked up or tripped without the other.
- R8: If any of blk_user, blk_vfail, blk_vt_mcb or blk_pole_dead is high at a clock edge, both stages' pickup flags, trip flags, timers and restraint counters clear at that edge.
- R9: After a block is removed, each stage evaluates afresh, and a restraint run that was under way before the block is not resumed.
- R10: Settings inputs are taken only at an edge where cfg_load is high, or during reset. Changing them while cfg_load is low has no effect on the outputs.
- R11: Cycles with smp_vld low leave pickup state unchanged, whatever smp_mag holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; settings captured while low |
| cfg_load | input | 1 | Capture all settings inputs at this edge |
| cfg_lo_thr | input | VW | Lower stage pickup threshold |
| cfg_lo_ratio | input | RW | Lower stage reset ratio, fraction of 2^RW |
| cfg_lo_delay | input | DW | Lower stage trip delay in clocks |
| cfg_hi_thr | input | VW | Higher stage pickup threshold |
| cfg_hi_ratio | input | RW | Higher stage reset ratio, fraction of 2^RW |
| cfg_hi_delay | input | DW | Higher stage trip delay in clocks |
| cfg_restraint_en | input | 1 | Enable the consecutive-sample restraint for both stages |
| smp_vld | input | 1 | Sample-valid strobe |
| smp_mag | input | VW | Voltage magnitude sample |
| blk_user | input | 1 | User block |
| blk_vfail | input | 1 | Voltage-failure monitor block |
| blk_vt_mcb | input | 1 | Transformer breaker-trip block |
| blk_pole_dead | input | 1 | Single-pole dead-time block |
| lo_pickup | output | 1 | Lower stage pickup |
| lo_trip | output | 1 | Lower stage trip |
| hi_pickup | output | 1 | Higher stage pickup |
| hi_trip | output | 1 | Higher stage trip |

## Verification
Pickup and dropout show up one clock after the edge that samples the valid strobe, and so does the clearing by any block source. A trip appears D+1 clocks after the pickup flag rises and falls on the same edge as the pickup. The bench drives every input just after a falling edge. It reads the flags at the following falling edge, which is exactly one rising edge later. For the trip delay it counts falling edges from the observed pickup and expects the trip at count D+1 and not before.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
   localparam int unsigned OVP_NSTAGE = 2;
   localparam int unsigned OVP_LO     = 0;
   localparam int unsigned OVP_HI     = 1;

   typedef struct packed {
      logic user;
      logic vfail;
      logic vt_mcb;
      logic pole_dead;
   } ovp_blk_t;

   function automatic logic ovp_any_block(ovp_blk_t b);
      return |b;
   endfunction
endpackage

// File: rtl/ovp_cfg_regs.sv
module ovp_cfg_regs #(
   parameter int unsigned VW = 16,
   parameter int unsigned RW = 8,
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [VW-1:0] thr_in,
   input  logic [RW-1:0] ratio_in,
   input  logic [DW-1:0] dly_in,
   output logic [VW-1:0] thr_q,
   output logic [VW-1:0] drop_q,
   output logic [DW-1:0] dly_q
);
   localparam int unsigned PW = VW + RW;

   logic [PW-1:0] prod;

   // drop-off level is computed once at capture, not per sample
   assign prod = PW'(thr_in) * PW'(ratio_in);

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         thr_q  <= thr_in;
         drop_q <= prod[PW-1:RW];
         dly_q  <= dly_in;
      end
   end

   // R3
   drop_below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load) |-> (drop_q <= thr_q));
endmodule

// File: rtl/ovp_pickup.sv
module ovp_pickup #(
   parameter int unsigned VW          = 16,
   parameter int unsigned RESTRAINT_N = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          blocked,
   input  logic          vld,
   input  logic [VW-1:0] mag,
   input  logic [VW-1:0] thr,
   input  logic [VW-1:0] drop,
   input  logic          rstr_en,
   output logic          pu_q,
   output logic          pu_nxt
);
   logic above;
   logic below;

   assign above = mag > thr;
   assign below = mag < drop;

   generate
      if (RESTRAINT_N > 1) begin : g_rstr
         localparam int unsigned CW = $clog2(RESTRAINT_N);
         localparam logic [CW-1:0] LAST = CW'(RESTRAINT_N - 1);

         logic [CW-1:0] cnt_q;
         logic [CW-1:0] cnt_nxt;

         always_comb begin
            pu_nxt  = pu_q;
            cnt_nxt = cnt_q;
            if (blocked) begin
               pu_nxt  = 1'b0;
               cnt_nxt = '0;
            end else if (vld) begin
               if (pu_q) begin
                  cnt_nxt = '0;
                  if (below) pu_nxt = 1'b0;
               end else if (above) begin
                  if (!rstr_en || cnt_q == LAST) begin
                     pu_nxt  = 1'b1;
                     cnt_nxt = '0;
                  end else begin
                     cnt_nxt = cnt_q + 1'b1;
                  end
               end else begin
                  cnt_nxt = '0;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pu_q  <= 1'b0;
               cnt_q <= '0;
            end else begin
               pu_q  <= pu_nxt;
               cnt_q <= cnt_nxt;
            end
         end

         // R4
         no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);

         // R9
         rstr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
            blocked |=> (cnt_q == '0));
      end else begin : g_direct
         always_comb begin
            pu_nxt = pu_q;
            if (blocked)                  pu_nxt = 1'b0;
            else if (vld && pu_q && below) pu_nxt = 1'b0;
            else if (vld && !pu_q && above) pu_nxt = 1'b1;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) pu_q <= 1'b0;
            else        pu_q <= pu_nxt;
         end
      end
   endgenerate

   // R2
   pu_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pu_q) |-> $past(vld && !blocked && (mag > thr)));

   // R3
   pu_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pu_q) |-> ($past(blocked) || $past(vld && (mag < drop))));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!vld && !blocked) |=> $stable(pu_q));
endmodule

// File: rtl/ovp_delay_timer.sv
module ovp_delay_timer #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pu_q,
   input  logic          pu_nxt,
   input  logic [DW-1:0] dly,
   output logic          trip_q
);
   logic [DW-1:0] tmr_q;

   // uses the next pickup state so the trip falls on the same edge
   always_ff @(posedge clk) begin
      if (!rst_n || !pu_nxt) begin
         tmr_q  <= '0;
         trip_q <= 1'b0;
      end else if (pu_q && !trip_q) begin
         if (tmr_q >= dly) trip_q <= 1'b1;
         else              tmr_q  <= tmr_q + 1'b1;
      end
   end

   // R5
   trip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trip_q) |-> ($past(pu_q) && ($past(tmr_q) >= $past(dly))));

   // R6
   trip_needs_pu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip_q |-> pu_q);
endmodule

// File: rtl/ovp_stage.sv
module ovp_stage #(
   parameter int unsigned VW          = 16,
   parameter int unsigned DW          = 16,
   parameter int unsigned RESTRAINT_N = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          blocked,
   input  logic          vld,
   input  logic [VW-1:0] mag,
   input  logic [VW-1:0] thr,
   input  logic [VW-1:0] drop,
   input  logic [DW-1:0] dly,
   input  logic          rstr_en,
   output logic          pickup,
   output logic          trip
);
   logic pu_q;
   logic pu_nxt;

   ovp_pickup #(.VW(VW), .RESTRAINT_N(RESTRAINT_N)) u_pu (
      .clk     (clk),
      .rst_n   (rst_n),
      .blocked (blocked),
      .vld     (vld),
      .mag     (mag),
      .thr     (thr),
      .drop    (drop),
      .rstr_en (rstr_en),
      .pu_q    (pu_q),
      .pu_nxt  (pu_nxt)
   );

   ovp_delay_timer #(.DW(DW)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .pu_q   (pu_q),
      .pu_nxt (pu_nxt),
      .dly    (dly),
      .trip_q (trip)
   );

   assign pickup = pu_q;

   // R8
   block_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> (!pickup && !trip));
endmodule

// File: rtl/ovp_two_stage.sv
module ovp_two_stage #(
   parameter int unsigned VW          = 16,
   parameter int unsigned RW          = 8,
   parameter int unsigned DW          = 16,
   parameter int unsigned RESTRAINT_N = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_load,
   input  logic [VW-1:0] cfg_lo_thr,
   input  logic [RW-1:0] cfg_lo_ratio,
   input  logic [DW-1:0] cfg_lo_delay,
   input  logic [VW-1:0] cfg_hi_thr,
   input  logic [RW-1:0] cfg_hi_ratio,
   input  logic [DW-1:0] cfg_hi_delay,
   input  logic          cfg_restraint_en,
   input  logic          smp_vld,
   input  logic [VW-1:0] smp_mag,
   input  logic          blk_user,
   input  logic          blk_vfail,
   input  logic          blk_vt_mcb,
   input  logic          blk_pole_dead,
   output logic          lo_pickup,
   output logic          lo_trip,
   output logic          hi_pickup,
   output logic          hi_trip
);
   import ovp_pkg::*;

   generate
      if (VW < 2) begin : g_bad_vw
         $error("VW must be at least 2");
      end
      if (RW < 1) begin : g_bad_rw
         $error("RW must be at least 1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be at least 1");
      end
      if (RESTRAINT_N < 1) begin : g_bad_rn
         $error("RESTRAINT_N must be at least 1");
      end
   endgenerate

   logic [VW-1:0] thr_in   [OVP_NSTAGE];
   logic [RW-1:0] ratio_in [OVP_NSTAGE];
   logic [DW-1:0] dly_in   [OVP_NSTAGE];
   logic [VW-1:0] thr_q    [OVP_NSTAGE];
   logic [VW-1:0] drop_q   [OVP_NSTAGE];
   logic [DW-1:0] dly_q    [OVP_NSTAGE];
   logic          pu       [OVP_NSTAGE];
   logic          tr       [OVP_NSTAGE];
   logic          rstr_en_q;
   ovp_blk_t      blk;
   logic          blocked;

   assign thr_in[OVP_LO]   = cfg_lo_thr;
   assign ratio_in[OVP_LO] = cfg_lo_ratio;
   assign dly_in[OVP_LO]   = cfg_lo_delay;
   assign thr_in[OVP_HI]   = cfg_hi_thr;
   assign ratio_in[OVP_HI] = cfg_hi_ratio;
   assign dly_in[OVP_HI]   = cfg_hi_delay;

   assign blk = '{user: blk_user, vfail: blk_vfail,
                  vt_mcb: blk_vt_mcb, pole_dead: blk_pole_dead};
   assign blocked = ovp_any_block(blk);

   always_ff @(posedge clk) begin
      if (!rst_n || cfg_load) rstr_en_q <= cfg_restraint_en;
   end

   generate
      for (genvar s = 0; s < OVP_NSTAGE; s++) begin : g_stage
         ovp_cfg_regs #(.VW(VW), .RW(RW), .DW(DW)) u_cfg (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cfg_load),
            .thr_in   (thr_in[s]),
            .ratio_in (ratio_in[s]),
            .dly_in   (dly_in[s]),
            .thr_q    (thr_q[s]),
            .drop_q   (drop_q[s]),
            .dly_q    (dly_q[s])
         );

         ovp_stage #(.VW(VW), .DW(DW), .RESTRAINT_N(RESTRAINT_N)) u_stg (
            .clk     (clk),
            .rst_n   (rst_n),
            .blocked (blocked),
            .vld     (smp_vld),
            .mag     (smp_mag),
            .thr     (thr_q[s]),
            .drop    (drop_q[s]),
            .dly     (dly_q[s]),
            .rstr_en (rstr_en_q),
            .pickup  (pu[s]),
            .trip    (tr[s])
         );
      end
   endgenerate

   assign lo_pickup = pu[OVP_LO];
   assign lo_trip   = tr[OVP_LO];
   assign hi_pickup = pu[OVP_HI];
   assign hi_trip   = tr[OVP_HI];

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!lo_pickup && !lo_trip && !hi_pickup && !hi_trip));

   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable(rstr_en_q));
endmodule

// File: tb/tb_ovp_two_stage.sv
module tb_ovp_two_stage;
   localparam int unsigned VW = 16;
   localparam int unsigned RW = 8;
   localparam int unsigned DW = 16;
   localparam int unsigned RN = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_load = 1'b0;
   logic [VW-1:0] cfg_lo_thr = 16'd1000;
   logic [RW-1:0] cfg_lo_ratio = 8'd192;   // drop 750
   logic [DW-1:0] cfg_lo_delay = 16'd5;
   logic [VW-1:0] cfg_hi_thr = 16'd2000;
   logic [RW-1:0] cfg_hi_ratio = 8'd230;   // drop 1796
   logic [DW-1:0] cfg_hi_delay = 16'd0;
   logic          cfg_restraint_en = 1'b0;
   logic          smp_vld = 1'b0;
   logic [VW-1:0] smp_mag = '0;
   logic          blk_user = 1'b0;
   logic          blk_vfail = 1'b0;
   logic          blk_vt_mcb = 1'b0;
   logic          blk_pole_dead = 1'b0;
   logic          lo_pickup, lo_trip, hi_pickup, hi_trip;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ovp_two_stage #(.VW(VW), .RW(RW), .DW(DW), .RESTRAINT_N(RN)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
      .cfg_lo_thr(cfg_lo_thr), .cfg_lo_ratio(cfg_lo_ratio), .cfg_lo_delay(cfg_lo_delay),
      .cfg_hi_thr(cfg_hi_thr), .cfg_hi_ratio(cfg_hi_ratio), .cfg_hi_delay(cfg_hi_delay),
      .cfg_restraint_en(cfg_restraint_en), .smp_vld(smp_vld), .smp_mag(smp_mag),
      .blk_user(blk_user), .blk_vfail(blk_vfail), .blk_vt_mcb(blk_vt_mcb),
      .blk_pole_dead(blk_pole_dead), .lo_pickup(lo_pickup), .lo_trip(lo_trip),
      .hi_pickup(hi_pickup), .hi_trip(hi_trip)
   );

   typedef struct packed {
      logic          vld;
      logic [15:0]   mag;
      logic [3:0]    blk;   // {user, vfail, vt_mcb, pole_dead}
      logic          exp_lo;
      logic          exp_hi;
   } vec_t;

   localparam int NVEC = 18;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 16'd500,  4'b0000, 1'b0, 1'b0},  // R2 below
      '{1'b1, 16'd1000, 4'b0000, 1'b0, 1'b0},  // R2 equal
      '{1'b1, 16'd1001, 4'b0000, 1'b1, 1'b0},  // R2 above
      '{1'b0, 16'd100,  4'b0000, 1'b1, 1'b0},  // R11 invalid
      '{1'b1, 16'd750,  4'b0000, 1'b1, 1'b0},  // R3 equal drop
      '{1'b1, 16'd749,  4'b0000, 1'b0, 1'b0},  // R3 below drop
      '{1'b1, 16'd2001, 4'b0000, 1'b1, 1'b1},  // R7 both
      '{1'b1, 16'd1800, 4'b0000, 1'b1, 1'b1},  // R3 hi hold
      '{1'b1, 16'd1795, 4'b0000, 1'b1, 1'b0},  // R7 hi drops alone
      '{1'b1, 16'd1500, 4'b0000, 1'b1, 1'b0},  // R7
      '{1'b1, 16'd3000, 4'b1000, 1'b0, 1'b0},  // R8 user
      '{1'b1, 16'd3000, 4'b0000, 1'b1, 1'b1},  // R9
      '{1'b1, 16'd3000, 4'b0100, 1'b0, 1'b0},  // R8 vfail
      '{1'b1, 16'd3000, 4'b0000, 1'b1, 1'b1},  // R9
      '{1'b0, 16'd3000, 4'b0010, 1'b0, 1'b0},  // R8 vt breaker
      '{1'b1, 16'd3000, 4'b0000, 1'b1, 1'b1},  // R9
      '{1'b1, 16'd3000, 4'b0001, 1'b0, 1'b0},  // R8 pole dead
      '{1'b1, 16'd0,    4'b0000, 1'b0, 1'b0}   // R11
   };

   task automatic chk(string req, logic act, logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(logic v, logic [15:0] m, logic [3:0] b);
      smp_vld = v;
      smp_mag = m;
      {blk_user, blk_vfail, blk_vt_mcb, blk_pole_dead} = b;
   endtask

   // drive now, observe one rising edge later
   task automatic step(logic v, logic [15:0] m, logic [3:0] b);
      drive(v, m, b);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 lo_pickup", lo_pickup, 1'b0);
      chk("R1 lo_trip",   lo_trip,   1'b0);
      chk("R1 hi_pickup", hi_pickup, 1'b0);
      chk("R1 hi_trip",   hi_trip,   1'b0);

      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i].vld, VEC[i].mag, VEC[i].blk);
         chk($sformatf("vec%0d lo", i), lo_pickup, VEC[i].exp_lo);
         chk($sformatf("vec%0d hi", i), hi_pickup, VEC[i].exp_hi);
      end

      // R5 lower delay 5: trip at 6th edge after pickup observed
      step(1'b1, 16'd1200, 4'b0000);
      chk("R5 lo pickup", lo_pickup, 1'b1);
      chk("R7 hi idle", hi_pickup, 1'b0);
      for (int k = 1; k <= 6; k++) begin
         step(1'b0, 16'd0, 4'b0000);
         chk($sformatf("R5 lo trip +%0d", k), lo_trip, (k >= 6));
      end
      step(1'b0, 16'd0, 4'b0000);
      chk("R5 lo trip held", lo_trip, 1'b1);
      // R6 trip clears with pickup
      step(1'b1, 16'd700, 4'b0000);
      chk("R6 lo pickup clear", lo_pickup, 1'b0);
      chk("R6 lo trip clear", lo_trip, 1'b0);

      // R5 higher delay 0: trip one clock after pickup
      step(1'b1, 16'd2500, 4'b0000);
      chk("R5 hi pickup", hi_pickup, 1'b1);
      chk("R5 hi trip not yet", hi_trip, 1'b0);
      step(1'b0, 16'd0, 4'b0000);
      chk("R5 hi trip", hi_trip, 1'b1);
      // R8 block clears trips
      step(1'b0, 16'd0, 4'b0010);
      chk("R8 hi trip blocked", hi_trip, 1'b0);
      chk("R8 lo pickup blocked", lo_pickup, 1'b0);

      // R4 restraint: load with restraint enabled
      cfg_restraint_en = 1'b1;
      cfg_load = 1'b1;
      step(1'b0, 16'd0, 4'b0000);
      cfg_load = 1'b0;
      step(1'b1, 16'd1200, 4'b0000);
      step(1'b1, 16'd1200, 4'b0000);
      chk("R4 two samples", lo_pickup, 1'b0);
      step(1'b0, 16'd1200, 4'b0000);
      step(1'b1, 16'd500, 4'b0000);
      chk("R4 restart", lo_pickup, 1'b0);
      step(1'b1, 16'd1200, 4'b0000);
      step(1'b0, 16'd0, 4'b0000);
      step(1'b1, 16'd1200, 4'b0000);
      chk("R4 gap ignored, two", lo_pickup, 1'b0);
      step(1'b1, 16'd1200, 4'b0000);
      chk("R4 third sample", lo_pickup, 1'b1);

      // R9 fresh run after block
      step(1'b1, 16'd700, 4'b0000);
      step(1'b1, 16'd1200, 4'b0000);
      step(1'b1, 16'd1200, 4'b0000);
      step(1'b0, 16'd0, 4'b1000);
      step(1'b1, 16'd1200, 4'b0000);
      chk("R9 not resumed", lo_pickup, 1'b0);
      step(1'b1, 16'd1200, 4'b0000);
      chk("R9 two after", lo_pickup, 1'b0);
      step(1'b1, 16'd1200, 4'b0000);
      chk("R9 three after", lo_pickup, 1'b1);
      step(1'b1, 16'd100, 4'b0000);

      // R10 no load: settings unchanged
      cfg_lo_thr = 16'd100;
      cfg_restraint_en = 1'b0;
      step(1'b1, 16'd500, 4'b0000);
      chk("R10 no load", lo_pickup, 1'b0);
      cfg_load = 1'b1;
      step(1'b0, 16'd0, 4'b0000);
      cfg_load = 1'b0;
      step(1'b1, 16'd500, 4'b0000);
      chk("R10 loaded", lo_pickup, 1'b1);

      finish_run();
   end
endmodule